// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a port of already-synchronized GPIO pins and raises interrupt flags when a pin shows the condition its sense setting asks for. Every pin has a small control register that selects one sense setting: off, active-low level, active-high level, rising edge, falling edge or either edge. Events latch into a status flag register with one bit per pin. All flags are ORed into a single interrupt line towards the processor.

Software programs and inspects the block over a simple word-addressed register bus with a write strobe and a combinational read path. A pin is masked by writing zero to its control register. A flag is acknowledged by writing a one to its bit in the status register. Edge senses compare the pin with its level from the previous clock. Level senses keep setting the flag for as long as the pin sits at the active level, so an acknowledge only holds once the pin has left that level.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every control register reads 0, every status flag is 0 and `irq` is low.
- R2: The control register of pin n sits at byte address n*4. Its 4-bit sense field is at bits 19:16, and all other bits read as 0. Addresses that are neither a control register nor the status register read as 0.
- R3: Sense 0x8 sets the flag on every clock edge that sees the pin low, and sense 0xC on every edge that sees it high. A flag that is cleared while the pin is still at its active level is set again by the same edge.
- R4: Sense 0x9 flags a 0-to-1 change, 0xA a 1-to-0 change and 0xB either change, each judged against the pin level sampled on the previous clock. The flag is visible right after the first clock edge that samples the new level.
- R5: Sense 0x0, and every code not named in R3 or R4, detects nothing. Writing 0 to a control register masks that pin.
- R6: The status register is at byte address 0xA0, with bit n holding the flag of pin n. Writing a 1 to a bit clears that flag, writing a 0 leaves it unchanged, and writing all ones clears every flag.
- R7: When an event and a clear hit the same flag on the same clock edge, the flag ends up set.
- R8: `irq` is high exactly while at least one status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | NUM_PINS (32) | Synchronized pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
A pin change driven before a clock edge shows up in the flag, in `bus_rdata` and in `irq` right after that edge, so there is one register stage and no extra delay. A control write takes effect at its edge, so detection with the new sense starts on the following edge. An acknowledge also lands at its own edge, so a clear and a pin change placed in the same cycle meet at one edge, which is how the collision rule is exercised. The bench drives every input on the falling clock edge and samples one falling edge after the rising edge that should produce the result. Reads are taken 1 ns into the low phase, which is well clear of both edges.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int SENSE_W = 4;

   typedef enum logic [SENSE_W-1:0] {
      SENSE_OFF  = 4'h0,
      SENSE_LOW  = 4'h8,
      SENSE_RISE = 4'h9,
      SENSE_FALL = 4'hA,
      SENSE_BOTH = 4'hB,
      SENSE_HIGH = 4'hC
   } sense_e;

   function automatic logic sense_is_live(input logic [SENSE_W-1:0] code);
      return (code == SENSE_LOW)  || (code == SENSE_RISE) ||
             (code == SENSE_FALL) || (code == SENSE_BOTH) ||
             (code == SENSE_HIGH);
   endfunction
endpackage

// File: rtl/gpio_irq_cfg_regs.sv
module gpio_irq_cfg_regs
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int ADDR_W   = 8
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [SENSE_W-1:0]           wr_field,
   output logic [NUM_PINS*SENSE_W-1:0]  cfg_flat
);
   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g * 4);
      logic [SENSE_W-1:0] field_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            field_q <= '0;
         end else if (wr_en && (wr_addr == MY_ADDR)) begin
            field_q <= wr_field;
         end
      end

      assign cfg_flat[g*SENSE_W +: SENSE_W] = field_q;
   end
endmodule

// File: rtl/gpio_irq_pin_sense.sv
module gpio_irq_pin_sense
   import gpio_irq_pkg::*;
(
   input  logic               clk,
   input  logic               rst,
   input  logic               pin,
   input  logic [SENSE_W-1:0] sense,
   output logic               hit
);
   logic last_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         last_q <= 1'b0;
      end else begin
         last_q <= pin;
      end
   end

   always_comb begin
      case (sense)
         SENSE_LOW:  hit = ~pin;
         SENSE_HIGH: hit = pin;
         SENSE_RISE: hit = pin & ~last_q;
         SENSE_FALL: hit = ~pin & last_q;
         SENSE_BOTH: hit = pin ^ last_q;
         default:    hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/gpio_irq_flags.sv
module gpio_irq_flags #(
   parameter int NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_PINS-1:0] hit,
   input  logic                clr_en,
   input  logic [NUM_PINS-1:0] clr_mask,
   output logic [NUM_PINS-1:0] flags
);
   logic [NUM_PINS-1:0] drop;

   assign drop = clr_en ? clr_mask : '0;

   // a fresh event outranks an acknowledge on the same edge
   always_ff @(posedge clk) begin
      if (rst) begin
         flags <= '0;
      end else begin
         flags <= (flags & ~drop) | hit;
      end
   end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int FIELD_LSB   = 16,
   parameter int STAT_OFFSET = 'hA0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq
);
   localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFFSET);

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..DATA_W");
   end
   if (FIELD_LSB + SENSE_W > DATA_W) begin : g_bad_field
      $error("sense field does not fit in DATA_W");
   end
   if (NUM_PINS * 4 > STAT_OFFSET || (STAT_OFFSET % 4) != 0) begin : g_bad_stat
      $error("status register overlaps control space or is misaligned");
   end
   if (STAT_OFFSET >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for status register");
   end

   logic [NUM_PINS*SENSE_W-1:0] cfg_flat;
   logic [NUM_PINS-1:0]         hit;
   logic [NUM_PINS-1:0]         flags_q;
   logic                        stat_wr;

   assign stat_wr = bus_wr && (bus_addr == STAT_ADDR);

   gpio_irq_cfg_regs #(
      .NUM_PINS (NUM_PINS),
      .ADDR_W   (ADDR_W)
   ) u_cfg (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (bus_wr),
      .wr_addr  (bus_addr),
      .wr_field (bus_wdata[FIELD_LSB +: SENSE_W]),
      .cfg_flat (cfg_flat)
   );

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_sense
      gpio_irq_pin_sense u_sense (
         .clk   (clk),
         .rst   (rst),
         .pin   (pin_in[g]),
         .sense (cfg_flat[g*SENSE_W +: SENSE_W]),
         .hit   (hit[g])
      );
   end

   gpio_irq_flags #(
      .NUM_PINS (NUM_PINS)
   ) u_flags (
      .clk      (clk),
      .rst      (rst),
      .hit      (hit),
      .clr_en   (stat_wr),
      .clr_mask (bus_wdata[NUM_PINS-1:0]),
      .flags    (flags_q)
   );

   assign irq = |flags_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == STAT_ADDR) begin
         bus_rdata[NUM_PINS-1:0] = flags_q;
      end else begin
         for (int i = 0; i < NUM_PINS; i++) begin
            if (bus_addr == ADDR_W'(i * 4)) begin
               bus_rdata[FIELD_LSB +: SENSE_W] = cfg_flat[i*SENSE_W +: SENSE_W];
            end
         end
      end
   end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int ADDR_W      = 8,
   parameter int STAT_OFFSET = 'hA0
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        bus_wr,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic                        irq,
   input logic [NUM_PINS-1:0]         flags,
   input logic [NUM_PINS*SENSE_W-1:0] cfg_flat
);
   localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFFSET);

   logic [NUM_PINS-1:0] live;
   logic                stat_wr;

   always_comb begin
      for (int i = 0; i < NUM_PINS; i++) begin
         live[i] = sense_is_live(cfg_flat[i*SENSE_W +: SENSE_W]);
      end
   end

   assign stat_wr = bus_wr && (bus_addr == STAT_ADDR);

   // R1: reset empties flags and control registers
   p_reset_clean_r1: assert property (@(posedge clk)
      rst |=> (flags == '0 && cfg_flat == '0));

   // R5: a pin whose sense is off or unlisted never gets a new flag
   p_dead_pin_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((flags & ~$past(flags) & ~$past(live)) == '0));

   // R6: flags only drop through a status write
   p_flags_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !stat_wr |=> ((flags & $past(flags)) == $past(flags)));

   // R8: interrupt line falls only after an acknowledge
   p_irq_fall_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(irq) |-> $past(stat_wr));

   // R8: interrupt line rises only when some pin was armed
   p_irq_rise_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(irq) |-> $past(|live));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(
   .NUM_PINS    (NUM_PINS),
   .ADDR_W      (ADDR_W),
   .STAT_OFFSET (STAT_OFFSET)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .irq      (irq),
   .flags    (flags_q),
   .cfg_flat (cfg_flat)
);

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb;
   localparam int NP = 32;
   localparam logic [7:0] STAT = 8'hA0;

   logic          clk = 1'b0;
   logic          rst;
   logic [NP-1:0] pin_in;
   logic          bus_wr;
   logic [7:0]    bus_addr;
   logic [31:0]   bus_wdata;
   logic [31:0]   bus_rdata;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   gpio_irq_detect u_dut (
      .clk       (clk),
      .rst       (rst),
      .pin_in    (pin_in),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // {pin[4:0], sense[3:0], level_before, level_after, expected_flag}
   localparam logic [11:0] VEC [16] = '{
      {5'd3,  4'h9, 1'b0, 1'b1, 1'b1},
      {5'd3,  4'h9, 1'b1, 1'b0, 1'b0},
      {5'd3,  4'h9, 1'b1, 1'b1, 1'b0},
      {5'd10, 4'hA, 1'b1, 1'b0, 1'b1},
      {5'd10, 4'hA, 1'b0, 1'b1, 1'b0},
      {5'd31, 4'hB, 1'b0, 1'b1, 1'b1},
      {5'd31, 4'hB, 1'b1, 1'b0, 1'b1},
      {5'd31, 4'hB, 1'b0, 1'b0, 1'b0},
      {5'd0,  4'h8, 1'b1, 1'b0, 1'b1},
      {5'd0,  4'h8, 1'b1, 1'b1, 1'b0},
      {5'd0,  4'h8, 1'b0, 1'b0, 1'b1},
      {5'd17, 4'hC, 1'b0, 1'b1, 1'b1},
      {5'd17, 4'hC, 1'b1, 1'b0, 1'b0},
      {5'd17, 4'hC, 1'b1, 1'b1, 1'b1},
      {5'd3,  4'h0, 1'b0, 1'b1, 1'b0},
      {5'd20, 4'h5, 1'b0, 1'b1, 1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      bus_wr    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      step();
      bus_wr    = 1'b0;
      bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic set_sense(input int p, input logic [3:0] s);
      bus_write(8'(p * 4), 32'(s) << 16);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      rst       = 1'b1;
      pin_in    = '0;
      bus_wr    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      repeat (3) step();
      rst = 1'b0;
      step();

      // R1: reset state
      rd(STAT, r);     check("R1 flags", r, 32'h0);
      check("R1 irq", 32'(irq), 32'h0);
      rd(8'h00, r);    check("R1 cfg pin0", r, 32'h0);
      rd(8'h7C, r);    check("R1 cfg pin31", r, 32'h0);

      // vector table: arm, then change pin and acknowledge on the same edge
      for (int k = 0; k < 16; k++) begin
         int          p;
         logic [3:0]  s;
         logic        l0, l1, e;
         string       tag;
         p  = int'(VEC[k][11:7]);
         s  = VEC[k][6:3];
         l0 = VEC[k][2];
         l1 = VEC[k][1];
         e  = VEC[k][0];
         if (s == 4'h8 || s == 4'hC) tag = $sformatf("R3 R7 vec%0d", k);
         else if (s == 4'h0 || s == 4'h5) tag = $sformatf("R5 vec%0d", k);
         else tag = $sformatf("R4 R7 vec%0d", k);
         pin_in[p] = l0;
         set_sense(p, s);
         step();
         pin_in[p] = l1;
         bus_write(STAT, 32'hFFFF_FFFF);
         rd(STAT, r);
         check(tag, r, 32'(e) << p);
         check({tag, " R8 irq"}, 32'(irq), 32'(e));
         set_sense(p, 4'h0);
         pin_in[p] = 1'b0;
         step();
         bus_write(STAT, 32'hFFFF_FFFF);
      end

      // R2: field position, readback masking, address decode
      bus_write(8'h24, 32'hFFFF_FFFF);
      rd(8'h24, r);  check("R2 readback pin9", r, 32'h000F_0000);
      rd(8'h20, r);  check("R2 pin8 untouched", r, 32'h0);
      rd(8'h26, r);  check("R2 unaligned addr", r, 32'h0);
      rd(8'hA4, r);  check("R2 unmapped addr", r, 32'h0);
      pin_in[9] = 1'b1;
      step();
      rd(STAT, r);   check("R5 code 0xF inert", r, 32'h0);
      pin_in[9] = 1'b0;
      set_sense(9, 4'h0);

      // R6 / R8: write-0 keeps, selective clear
      set_sense(2, 4'h9);
      set_sense(4, 4'h9);
      pin_in[2] = 1'b1;
      pin_in[4] = 1'b1;
      step();
      rd(STAT, r);   check("R6 two flags set", r, 32'h14);
      bus_write(STAT, 32'h0);
      rd(STAT, r);   check("R6 write zero keeps", r, 32'h14);
      bus_write(STAT, 32'h4);
      rd(STAT, r);   check("R6 clear bit2 only", r, 32'h10);
      check("R8 irq with one flag", 32'(irq), 32'h1);
      bus_write(STAT, 32'h10);
      rd(STAT, r);   check("R6 clear bit4", r, 32'h0);
      check("R8 irq low", 32'(irq), 32'h0);
      set_sense(2, 4'h0);
      set_sense(4, 4'h0);
      pin_in = '0;

      // R3: level flag returns after acknowledge; R5: writing 0 masks
      set_sense(6, 4'hC);
      pin_in[6] = 1'b1;
      step();
      bus_write(STAT, 32'h40);
      step();
      rd(STAT, r);   check("R3 level re-set", r, 32'h40);
      set_sense(6, 4'h0);
      bus_write(STAT, 32'hFFFF_FFFF);
      step();
      rd(STAT, r);   check("R5 masked pin silent", r, 32'h0);
      check("R5 irq low", 32'(irq), 32'h0);
      pin_in[6] = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule